// File: doc/BRIEF.md
# Time-Slot Switch Control Register Unit

This block is the control register front of a time-slot switch. A byte-wide register port reaches three registers. The first is an output enable register, which gates the bus clock drivers, the bus data drivers and the auxiliary I/O. The second is a write-triggered command register, which starts or pauses virtual channel switching. A command either takes effect at once or waits for the next 8 kHz frame pulse. The third is a memory mode register, which picks the data memory configuration and turns subrate switching on or off. An interface-mode strap tells the block whether the host is a PCI bridge (`host_cpu` = 0) or a plain microprocessor bus (`host_cpu` = 1). In the microprocessor case, some settings are not allowed.

The command logic is a six-state machine. Each state holds the present activity (on or off) and whether a frame-synchronized command is waiting. The states are:

- `S_OFF`: paused, nothing waiting.
- `S_ON`: running, nothing waiting.
- `S_OFF_ARM_ON`: paused, start waiting.
- `S_ON_ARM_ON`: running, start waiting.
- `S_OFF_ARM_OFF`: paused, pause waiting.
- `S_ON_ARM_OFF`: running, pause waiting.

The transitions are:

- **go-now** (code 0x11) moves any state to `S_ON`.
- **halt-now** (code 0x02) moves any state to `S_OFF`.
- **arm-go** (code 0x01) moves to `S_ON_ARM_ON` if running, otherwise to `S_OFF_ARM_ON`.
- **arm-halt** (code 0x12) moves to `S_ON_ARM_OFF` if running, otherwise to `S_OFF_ARM_OFF`.
- **frame-apply** runs on a frame pulse with no command taken in the same cycle. It moves both start-waiting states to `S_ON` and both pause-waiting states to `S_OFF`.

Reads are combinational from `addr`.

Top module: `swctl_regs`

## Requirements
- R1: After reset, `out_en` = 0, `sw_active` = 0, `subrate_en` = 0 and `mem_cfg` = 1. Reads return 0x00 at 0x103, 0x00 at 0x104 and 0x01 at 0x105.
- R2: A write to 0x103 stores the byte, and a read of 0x103 returns it. For i = 0 to 5, `out_en[i]` follows stored bit i.
- R3: Stored bit 7 of 0x103 (enable-all) forces `out_en[5:0]` to all ones. It has no effect on `out_en[6]`.
- R4: `out_en[6]` (bridge enable) equals stored bit 6 when `host_cpu` = 0. It is 0 whenever `host_cpu` = 1, whatever is stored.
- R5: Writing 0x11 to 0x104 sets `sw_active` from the next clock edge. Writing 0x02 clears it from the next clock edge. Either write discards any waiting command.
- R6: Writing 0x01 (start) or 0x12 (pause) to 0x104 leaves `sw_active` unchanged until the clock edge at which `frame_pulse` is sampled high. From that edge the waiting action applies.
- R7: A read of 0x104 returns the waiting command code (0x01 or 0x12) while one is held. It returns 0x00 otherwise, including once the action has been applied.
- R8: A later 0x01 or 0x12 write replaces a waiting command. A 0x00 write changes nothing and does not cancel a waiting command.
- R9: If a 0x11, 0x02, 0x01 or 0x12 write falls in the same cycle as `frame_pulse`, the previously waiting command is dropped and the written command acts as if alone. A 0x00 or unlisted write in a frame-pulse cycle does not block the frame-apply.
- R10: A write to 0x104 of any code other than 0x00, 0x11, 0x02, 0x01 or 0x12 is ignored.
- R11: Register 0x105 holds `subrate_en` in bit 7 and `mem_cfg` in bits 6:0. A write is accepted only if bits 6:0 are 1 to 6 (`host_cpu` = 0) or 1 to 3 (`host_cpu` = 1). Otherwise the whole write is ignored. A read returns the stored byte.
- R12: Reads of any other address return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (12) | Byte address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| frame_pulse | input | 1 | One-cycle 8 kHz frame reference |
| host_cpu | input | 1 | Interface strap: 1 = microprocessor bus, 0 = PCI |
| out_en | output | 7 | Output enables: [6] bridge, [5] frame I/O, [4] GPIO, [3] H clocks, [2] H data, [1] L clocks, [0] L data |
| sw_active | output | 1 | Virtual channel switching running |
| subrate_en | output | 1 | Subrate switching enable |
| mem_cfg | output | 7 | Data memory configuration code |

## Verification
Several rules are checked by assertions on every cycle:

- immediate commands land on the next edge;
- with no write and no frame pulse, `sw_active` and the waiting code hold;
- the bridge enable stays low in microprocessor mode;
- an enable-all write raises the six lower enables;
- unlisted command codes and rejected memory configurations leave the state unchanged.

Some behaviour only the bench's ordered scenarios can show, by comparing against a behavioural reference model on every clock:

- a waiting command replaced by a later one;
- an immediate command cancelling a waiting one;
- a write landing in the same cycle as a frame pulse;
- a 0x00 write leaving a waiting command in place;
- the memory configuration limit moving when the strap changes.

// File: rtl/swctl_pkg.sv
package swctl_pkg;
    typedef enum logic [2:0] {
        S_OFF         = 3'd0,
        S_ON          = 3'd1,
        S_OFF_ARM_ON  = 3'd2,
        S_ON_ARM_ON   = 3'd3,
        S_OFF_ARM_OFF = 3'd4,
        S_ON_ARM_OFF  = 3'd5
    } sw_state_e;

    localparam logic [7:0] CMD_NOP      = 8'h00;
    localparam logic [7:0] CMD_GO_NOW   = 8'h11;
    localparam logic [7:0] CMD_HALT_NOW = 8'h02;
    localparam logic [7:0] CMD_GO_FRM   = 8'h01;
    localparam logic [7:0] CMD_HALT_FRM = 8'h12;
endpackage

// File: rtl/swctl_enable_reg.sv
module swctl_enable_reg #(
    parameter int N_EN = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [7:0]      wdata,
    input  logic            host_cpu,
    output logic [7:0]      q,
    output logic [N_EN-1:0] en
);
    localparam int ALL_BIT    = 7;
    localparam int BRIDGE_BIT = N_EN - 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 8'h00;
        else if (wr) q <= wdata;
    end

    // Lower enables: individual bit or the enable-all override
    for (genvar i = 0; i < BRIDGE_BIT; i++) begin : g_lower
        assign en[i] = q[ALL_BIT] | q[i];
    end

    // Bridge enable ignores enable-all and is dead in microprocessor mode
    assign en[BRIDGE_BIT] = q[BRIDGE_BIT] & ~host_cpu;

    assert_bridge_cpu_R4: assert property (@(posedge clk) disable iff (!rst_n)
        host_cpu |-> !en[BRIDGE_BIT]);

    assert_enable_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[ALL_BIT]) |=> (&en[BRIDGE_BIT-1:0]));
endmodule

// File: rtl/swctl_memsel_reg.sv
module swctl_memsel_reg #(
    parameter int          CFG_W    = 7,
    parameter int          MAX_FULL = 6,
    parameter int          MAX_CPU  = 3,
    parameter int          CFG_RST  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [7:0]       wdata,
    input  logic             host_cpu,
    output logic [7:0]       q,
    output logic             subrate_en,
    output logic [CFG_W-1:0] mem_cfg
);
    localparam logic [CFG_W-1:0] LIM_FULL = CFG_W'(MAX_FULL);
    localparam logic [CFG_W-1:0] LIM_CPU  = CFG_W'(MAX_CPU);
    localparam logic [7:0]       Q_RST    = 8'(CFG_RST);

    logic [CFG_W-1:0] cfg_in;
    logic [CFG_W-1:0] limit;
    logic             accept;

    assign cfg_in = wdata[CFG_W-1:0];
    assign limit  = host_cpu ? LIM_CPU : LIM_FULL;
    assign accept = (cfg_in != '0) && (cfg_in <= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= Q_RST;
        else if (wr && accept) q <= wdata;
    end

    assign subrate_en = q[7];
    assign mem_cfg    = q[CFG_W-1:0];

    assert_reject_cfg_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (wdata[CFG_W-1:0] == '0 ||
                (host_cpu && wdata[CFG_W-1:0] > LIM_CPU) ||
                wdata[CFG_W-1:0] > LIM_FULL)) |=> $stable(q));

    assert_accept_cfg_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[CFG_W-1:0] == 1) |=> (mem_cfg == 1 && subrate_en == $past(wdata[7])));
endmodule

// File: rtl/swctl_cmd_fsm.sv
module swctl_cmd_fsm
    import swctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_code,
    input  logic       frame_pulse,
    output logic       sw_active,
    output logic [7:0] pend_code
);
    sw_state_e state_q, state_d;

    logic is_go_now, is_halt_now, is_go_frm, is_halt_frm, cmd_take;

    assign is_go_now   = (cmd_code == CMD_GO_NOW);
    assign is_halt_now = (cmd_code == CMD_HALT_NOW);
    assign is_go_frm   = (cmd_code == CMD_GO_FRM);
    assign is_halt_frm = (cmd_code == CMD_HALT_FRM);
    assign cmd_take    = cmd_wr && (is_go_now || is_halt_now || is_go_frm || is_halt_frm);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    // Outputs decoded from state
    always_comb begin
        sw_active = 1'b0;
        pend_code = CMD_NOP;
        unique case (state_q)
            S_OFF:         begin sw_active = 1'b0; pend_code = CMD_NOP;      end
            S_ON:          begin sw_active = 1'b1; pend_code = CMD_NOP;      end
            S_OFF_ARM_ON:  begin sw_active = 1'b0; pend_code = CMD_GO_FRM;   end
            S_ON_ARM_ON:   begin sw_active = 1'b1; pend_code = CMD_GO_FRM;   end
            S_OFF_ARM_OFF: begin sw_active = 1'b0; pend_code = CMD_HALT_FRM; end
            S_ON_ARM_OFF:  begin sw_active = 1'b1; pend_code = CMD_HALT_FRM; end
            default:       begin sw_active = 1'b0; pend_code = CMD_NOP;      end
        endcase
    end

    // Next state: a taken command wins over the frame pulse
    always_comb begin
        state_d = state_q;
        if (cmd_take) begin
            if (is_go_now)        state_d = S_ON;
            else if (is_halt_now) state_d = S_OFF;
            else if (is_go_frm)   state_d = sw_active ? S_ON_ARM_ON  : S_OFF_ARM_ON;
            else                  state_d = sw_active ? S_ON_ARM_OFF : S_OFF_ARM_OFF;
        end else if (frame_pulse) begin
            unique case (state_q)
                S_OFF_ARM_ON, S_ON_ARM_ON:   state_d = S_ON;
                S_OFF_ARM_OFF, S_ON_ARM_OFF: state_d = S_OFF;
                default:                     state_d = state_q;
            endcase
        end
    end

    assert_go_now_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_code == CMD_GO_NOW) |=> (sw_active && pend_code == CMD_NOP));

    assert_halt_now_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_code == CMD_HALT_NOW) |=> (!sw_active && pend_code == CMD_NOP));

    assert_frame_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_pulse && !cmd_wr && pend_code == CMD_GO_FRM) |=> (sw_active && pend_code == CMD_NOP));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_wr && !frame_pulse) |=> ($stable(sw_active) && $stable(pend_code)));

    assert_unlisted_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !frame_pulse && cmd_code != CMD_NOP && cmd_code != CMD_GO_NOW &&
         cmd_code != CMD_HALT_NOW && cmd_code != CMD_GO_FRM && cmd_code != CMD_HALT_FRM)
        |=> ($stable(sw_active) && $stable(pend_code)));
endmodule

// File: rtl/swctl_regs.sv
module swctl_regs #(
    parameter int              ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] OFS_EN  = 12'h103,
    parameter logic [ADDR_W-1:0] OFS_CMD = 12'h104,
    parameter logic [ADDR_W-1:0] OFS_MEM = 12'h105
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              frame_pulse,
    input  logic              host_cpu,
    output logic [6:0]        out_en,
    output logic              sw_active,
    output logic              subrate_en,
    output logic [6:0]        mem_cfg
);
    localparam int N_EN  = 7;
    localparam int CFG_W = 7;

    logic       sel_en, sel_cmd, sel_mem;
    logic [7:0] en_q, mem_q, pend_code;

    assign sel_en  = (addr == OFS_EN);
    assign sel_cmd = (addr == OFS_CMD);
    assign sel_mem = (addr == OFS_MEM);

    swctl_enable_reg #(.N_EN(N_EN)) u_en (
        .clk(clk), .rst_n(rst_n), .wr(wr_en && sel_en), .wdata(wdata),
        .host_cpu(host_cpu), .q(en_q), .en(out_en)
    );

    swctl_cmd_fsm u_cmd (
        .clk(clk), .rst_n(rst_n), .cmd_wr(wr_en && sel_cmd), .cmd_code(wdata),
        .frame_pulse(frame_pulse), .sw_active(sw_active), .pend_code(pend_code)
    );

    swctl_memsel_reg #(.CFG_W(CFG_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr(wr_en && sel_mem), .wdata(wdata),
        .host_cpu(host_cpu), .q(mem_q), .subrate_en(subrate_en), .mem_cfg(mem_cfg)
    );

    always_comb begin
        if (sel_en)       rdata = en_q;
        else if (sel_cmd) rdata = pend_code;
        else if (sel_mem) rdata = mem_q;
        else              rdata = 8'h00;
    end
endmodule

// File: tb/tb_swctl_regs.sv
`timescale 1ns/1ps
module tb_swctl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = 12'h000;
    logic [7:0]  wdata = 8'h00;
    logic        frame_pulse = 1'b0;
    logic        host_cpu = 1'b0;
    logic [7:0]  rdata;
    logic [6:0]  out_en;
    logic        sw_active, subrate_en;
    logic [6:0]  mem_cfg;

    int n_cmp = 0, n_bad = 0, cycles = 0;
    bit cmp_on = 0, done = 0;
    string cur_req = "R1";

    // Reference model state
    int m_en = 0, m_act = 0, m_pend = 0, m_mem = 1;

    swctl_regs dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .frame_pulse(frame_pulse), .host_cpu(host_cpu),
        .out_en(out_en), .sw_active(sw_active), .subrate_en(subrate_en), .mem_cfg(mem_cfg)
    );

    always #2 clk = ~clk;

    // Behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_act = 0; m_pend = 0; m_mem = 1;
        end else begin
            bit taken;
            int cfg, lim;
            taken = 0;
            if (wr_en && addr == 12'h103) m_en = wdata;
            if (wr_en && addr == 12'h104) begin
                case (wdata)
                    8'h11: begin m_act = 1; m_pend = 0; taken = 1; end
                    8'h02: begin m_act = 0; m_pend = 0; taken = 1; end
                    8'h01: begin m_pend = 8'h01; taken = 1; end
                    8'h12: begin m_pend = 8'h12; taken = 1; end
                    default: ;
                endcase
            end
            if (!taken && frame_pulse && m_pend != 0) begin
                m_act = (m_pend == 8'h01) ? 1 : 0;
                m_pend = 0;
            end
            if (wr_en && addr == 12'h105) begin
                cfg = wdata & 8'h7f;
                lim = host_cpu ? 3 : 6;
                if (cfg >= 1 && cfg <= lim) m_mem = wdata;
            end
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            int exp_en, exp_rd;
            exp_en = 0;
            for (int i = 0; i < 6; i++)
                if (((m_en >> 7) & 1) || ((m_en >> i) & 1)) exp_en |= (1 << i);
            if (((m_en >> 6) & 1) && !host_cpu) exp_en |= (1 << 6);
            case (addr)
                12'h103: exp_rd = m_en;
                12'h104: exp_rd = m_pend;
                12'h105: exp_rd = m_mem;
                default: exp_rd = 0;
            endcase
            chk("out_en", out_en, exp_en);
            chk("sw_active", sw_active, m_act);
            chk("subrate_en", subrate_en, (m_mem >> 7) & 1);
            chk("mem_cfg", mem_cfg, m_mem & 8'h7f);
            chk("rdata", rdata, exp_rd);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            finish_run();
        end
    end

    task automatic wr(input logic [11:0] a, input logic [7:0] d, input bit fr = 0);
        @(negedge clk); #1;
        wr_en = 1; addr = a; wdata = d; frame_pulse = fr;
        @(negedge clk); #1;
        wr_en = 0; frame_pulse = 0;
    endtask

    task automatic look(input logic [11:0] a, input int n);
        @(negedge clk); #1;
        addr = a;
        repeat (n) @(negedge clk);
    endtask

    task automatic frame();
        @(negedge clk); #1;
        frame_pulse = 1; addr = 12'h104;
        @(negedge clk); #1;
        frame_pulse = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1; cmp_on = 1;
        // R1 reset values
        cur_req = "R1 reset";
        look(12'h103, 2); look(12'h104, 2); look(12'h105, 2);
        // R2 individual enables and read-back
        cur_req = "R2 enable bits";
        wr(12'h103, 8'h15); look(12'h103, 2);
        wr(12'h103, 8'h2A); look(12'h103, 2);
        // R3 enable-all
        cur_req = "R3 enable-all";
        wr(12'h103, 8'h80); look(12'h103, 2);
        wr(12'h103, 8'h81); look(12'h103, 2);
        // R4 bridge enable and strap
        cur_req = "R4 bridge";
        wr(12'h103, 8'hC0); look(12'h103, 2);
        host_cpu = 1; look(12'h103, 2);
        wr(12'h103, 8'h40); look(12'h103, 2);
        host_cpu = 0; look(12'h103, 2);
        wr(12'h103, 8'h00);
        // R5 immediate start / pause
        cur_req = "R5 immediate";
        wr(12'h104, 8'h11); look(12'h104, 2);
        wr(12'h104, 8'h02); look(12'h104, 2);
        // R6 and R7 frame-synchronized commands, pending read-back
        cur_req = "R6 R7 deferred start";
        wr(12'h104, 8'h01); look(12'h104, 4); frame(); look(12'h104, 2);
        cur_req = "R6 R7 deferred pause";
        wr(12'h104, 8'h12); look(12'h104, 4); frame(); look(12'h104, 2);
        // R8 replacement, cancel, no-op
        cur_req = "R8 replace";
        wr(12'h104, 8'h01); wr(12'h104, 8'h12); frame(); look(12'h104, 2);
        cur_req = "R8 cancel";
        wr(12'h104, 8'h01); wr(12'h104, 8'h02); frame(); look(12'h104, 2);
        cur_req = "R8 nop keeps pending";
        wr(12'h104, 8'h01); wr(12'h104, 8'h00); look(12'h104, 2); frame(); look(12'h104, 2);
        // R9 collision of write and frame pulse
        cur_req = "R9 write with frame";
        wr(12'h104, 8'h12); wr(12'h104, 8'h01, 1); look(12'h104, 2);
        frame(); look(12'h104, 2);
        wr(12'h104, 8'h12); wr(12'h104, 8'h00, 1); look(12'h104, 2);
        wr(12'h104, 8'h01); wr(12'h104, 8'h11, 1); look(12'h104, 2);
        // R10 unlisted codes
        cur_req = "R10 unlisted";
        wr(12'h104, 8'h12); wr(12'h104, 8'h05); wr(12'h104, 8'hFF);
        wr(12'h104, 8'h10); look(12'h104, 2); frame(); look(12'h104, 2);
        // R11 memory mode register
        cur_req = "R11 memory mode";
        wr(12'h105, 8'h86); look(12'h105, 2);
        wr(12'h105, 8'h07); look(12'h105, 2);
        wr(12'h105, 8'h80); look(12'h105, 2);
        host_cpu = 1;
        wr(12'h105, 8'h04); look(12'h105, 2);
        wr(12'h105, 8'h03); look(12'h105, 2);
        wr(12'h105, 8'h82); look(12'h105, 2);
        host_cpu = 0;
        // R12 unmapped reads
        cur_req = "R12 unmapped";
        look(12'h000, 2); look(12'h106, 2); look(12'hFFF, 2);
        wr(12'h200, 8'hFF); look(12'h102, 2);
        finish_run();
    end
endmodule